// File: doc/BRIEF.md
# Sampling Phase Tuning Window Search

This engine picks a receive sampling delay by trying every setting of an 8-bit delay field in turn. When a run starts it captures the stored per-mode delay word and the configuration word. It writes the configuration word back out once with the compensation-enable nibble cleared. Then it asks an external responder to test each setting from 0 up to 255. For every test it presents the setting and the full candidate delay word, and waits for a pass or fail answer.

While the sweep runs, the engine tracks the longest unbroken run of passing settings. When the sweep ends it selects the middle of that run. The selected setting is merged into one byte lane of the stored delay word: bits [15:8] in command mode, or bits [23:16] in read-data mode. If no setting passed, the engine raises an error flag and returns the stored word unchanged.

Top module: `tune_top`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `cfgWe` and `probeReq` are 0, and `chosen` and `dlyOut` are 0.
- R2: A `start` pulse while idle makes `cfgWe` high for exactly one cycle, before the first `probeReq`. During that cycle `cfgOut` equals the captured `cfgIn` with bits [27:24] forced to 0 and all other bits unchanged.
- R3: Settings 0 to 255 are each offered exactly once, in increasing order, on `probeIdx`. `probeReq` stays high and `probeIdx` stays stable until `probeAck` is seen. Each acknowledged cycle consumes one setting.
- R4: During the sweep, `probeDly` equals the captured stored word with the setting in bits [15:8] when `dataMode`=0 (command mode), or in bits [23:16] when `dataMode`=1. All other bits are unchanged.
- R5: Each failing setting ends the current run of passes, so passing settings separated by a failure never join into one run. The longest run is kept, and between runs of equal length the one ending earlier wins.
- R6: A run that is still passing at setting 255 is closed at the end of the sweep and competes like any other run.
- R7: The chosen setting is `end - (length - 1) / 2` with integer division, where `end` is the last setting of the winning run and `length` is its number of settings.
- R8: On success, `err`=0, `chosen` holds the chosen setting, and `dlyOut` is the captured stored word with the chosen setting in the lane selected by the captured mode.
- R9: If no setting passes, `err`=1, `chosen`=0, and `dlyOut` equals the captured stored word unchanged.
- R10: `done` is a one-cycle pulse while `busy` is 0. `err`, `chosen` and `dlyOut` hold their values until the next run completes. A `start`, `dataMode`, `storedDly` or `cfgIn` change while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| dataMode | input | 1 | 0 = command lane [15:8], 1 = read-data lane [23:16] |
| storedDly | input | 32 | Stored delay word for the selected mode |
| cfgIn | input | 32 | Current configuration word |
| cfgOut | output | 32 | Configuration word with compensation nibble cleared |
| cfgWe | output | 1 | Write strobe for `cfgOut` |
| probeReq | output | 1 | Test request for the current setting |
| probeIdx | output | 8 | Setting under test |
| probeDly | output | 32 | Candidate delay word for the setting under test |
| probeAck | input | 1 | Responder has a result for the current request |
| probePass | input | 1 | Result valid with `probeAck`: 1 = pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No setting passed |
| chosen | output | 8 | Selected setting |
| dlyOut | output | 32 | Final delay word |

## Verification
A `start` taken at an edge makes `cfgWe` visible one cycle later, and the first request follows in the next cycle. Each acknowledged request moves on to the next setting at that edge, so a sweep with no stalls takes 256 cycles. Three cycles after the last acknowledge, `done` rises together with the final outputs. The bench responds and samples on the falling edge, so each check reads values already settled from the preceding rising edge. The scoreboard pops one expected result per `done` and compares it there. Sequence, lane and configuration checks are made on every request and gathered per run, and outputs are checked again after the run to confirm they hold.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_REQ,
    ST_CLOSE,
    ST_FIN
  } tuneState_e;

  typedef struct packed {
    logic clear;   // capture inputs, reset run tracking
    logic sample;  // one tested setting is consumed
    logic close;   // close a run still open at the last setting
    logic latch;   // register the final result
  } tuneStrobe_t;
endpackage

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             probeAck,
  output tuneStrobe_t      strb,
  output logic             busy,
  output logic             cfgWe,
  output logic             probeReq,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  tuneState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_CFG;
          idx   <= '0;
        end
        ST_CFG:  state <= ST_REQ;
        ST_REQ: if (probeAck) begin
          if (idx == LAST) state <= ST_CLOSE;
          else             idx   <= idx + 1'b1;
        end
        ST_CLOSE: state <= ST_FIN;
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clear  = (state == ST_IDLE) && start;
    strb.sample = (state == ST_REQ) && probeAck;
    strb.close  = (state == ST_CLOSE);
    strb.latch  = (state == ST_FIN);
    busy        = (state != ST_IDLE);
    cfgWe       = (state == ST_CFG);
    probeReq    = (state == ST_REQ);
  end
endmodule

// File: rtl/tune_dp.sv
module tune_dp
  import tune_pkg::*;
#(
  parameter int DLY_W    = 32,
  parameter int IDX_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tuneStrobe_t      strb,
  input  logic [IDX_W-1:0] idx,
  input  logic             pass,
  input  logic             dataMode,
  input  logic [DLY_W-1:0] storedDly,
  input  logic [DLY_W-1:0] cfgIn,
  output logic [DLY_W-1:0] cfgOut,
  output logic [DLY_W-1:0] probeDly,
  output logic             done,
  output logic             err,
  output logic [IDX_W-1:0] chosen,
  output logic [DLY_W-1:0] dlyOut
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};
  localparam logic [DLY_W-1:0] CPST_MASK =
    {{(DLY_W-CPST_W){1'b0}}, {CPST_W{1'b1}}} << CPST_LSB;

  logic             modeQ;
  logic [DLY_W-1:0] storedQ;
  logic [DLY_W-1:0] cfgQ;
  logic [CNT_W-1:0] runLen;
  logic [CNT_W-1:0] bestLen;
  logic [IDX_W-1:0] bestEnd;
  logic [IDX_W-1:0] pick;

  function automatic logic [DLY_W-1:0] mergeLane(input logic [DLY_W-1:0] w,
                                                 input logic [IDX_W-1:0] v,
                                                 input logic m);
    logic [DLY_W-1:0] r;
    r = w;
    for (int i = 0; i < IDX_W; i++) begin
      if (m) r[DATA_LSB+i] = v[i];
      else   r[CMD_LSB+i]  = v[i];
    end
    return r;
  endfunction

  logic [CNT_W-1:0] halfSpan;
  logic [CNT_W-1:0] endWide;
  logic [CNT_W-1:0] pickWide;

  always_comb begin
    cfgOut   = cfgQ & ~CPST_MASK;
    probeDly = mergeLane(storedQ, idx, modeQ);
    halfSpan = (bestLen - 1'b1) >> 1;
    endWide  = {1'b0, bestEnd};
    pickWide = endWide - halfSpan;
    pick     = pickWide[IDX_W-1:0];
  end

  // capture and run tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      storedQ <= '0;
      cfgQ    <= '0;
      runLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (strb.clear) begin
      modeQ   <= dataMode;
      storedQ <= storedDly;
      cfgQ    <= cfgIn;
      runLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (strb.sample) begin
      if (pass) begin
        runLen <= runLen + 1'b1;
      end else begin
        if (runLen > bestLen) begin
          bestLen <= runLen;
          bestEnd <= idx - 1'b1;
        end
        runLen <= '0;
      end
    end else if (strb.close) begin
      if (runLen > bestLen) begin
        bestLen <= runLen;
        bestEnd <= LAST;
      end
      runLen <= '0;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done   <= 1'b0;
      err    <= 1'b0;
      chosen <= '0;
      dlyOut <= '0;
    end else begin
      done <= strb.latch;
      if (strb.latch) begin
        if (bestLen == '0) begin
          err    <= 1'b1;
          chosen <= '0;
          dlyOut <= storedQ;
        end else begin
          err    <= 1'b0;
          chosen <= pick;
          dlyOut <= mergeLane(storedQ, pick, modeQ);
        end
      end
    end
  end
endmodule

// File: rtl/tune_top.sv
module tune_top
  import tune_pkg::*;
#(
  parameter int DLY_W    = 32,
  parameter int IDX_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dataMode,
  input  logic [DLY_W-1:0] storedDly,
  input  logic [DLY_W-1:0] cfgIn,
  output logic [DLY_W-1:0] cfgOut,
  output logic             cfgWe,
  output logic             probeReq,
  output logic [IDX_W-1:0] probeIdx,
  output logic [DLY_W-1:0] probeDly,
  input  logic             probeAck,
  input  logic             probePass,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [IDX_W-1:0] chosen,
  output logic [DLY_W-1:0] dlyOut
);
  tuneStrobe_t strb;

  tune_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .probeAck (probeAck),
    .strb     (strb),
    .busy     (busy),
    .cfgWe    (cfgWe),
    .probeReq (probeReq),
    .idx      (probeIdx)
  );

  tune_dp #(
    .DLY_W(DLY_W), .IDX_W(IDX_W), .CMD_LSB(CMD_LSB),
    .DATA_LSB(DATA_LSB), .CPST_LSB(CPST_LSB), .CPST_W(CPST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .idx       (probeIdx),
    .pass      (probePass),
    .dataMode  (dataMode),
    .storedDly (storedDly),
    .cfgIn     (cfgIn),
    .cfgOut    (cfgOut),
    .probeDly  (probeDly),
    .done      (done),
    .err       (err),
    .chosen    (chosen),
    .dlyOut    (dlyOut)
  );
endmodule

// File: rtl/tune_chk.sv
module tune_chk #(
  parameter int DLY_W    = 32,
  parameter int IDX_W    = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic             probeReq,
  input logic [IDX_W-1:0] probeIdx,
  input logic [DLY_W-1:0] probeDly,
  input logic             probeAck,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [IDX_W-1:0] chosen
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  assert_cfg_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> !cfgWe);

  assert_cfg_before_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> !probeReq);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (probeReq && !probeAck) |=> (probeReq && $stable(probeIdx)));

  assert_req_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (probeReq && probeAck && probeIdx != LAST) |=>
      (probeReq && probeIdx == IDX_W'($past(probeIdx) + 1'b1)));

  assert_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    probeReq |-> (probeDly[CMD_LSB +: IDX_W] == probeIdx ||
                  probeDly[DATA_LSB +: IDX_W] == probeIdx));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (chosen == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind tune_top tune_chk #(
  .DLY_W(DLY_W), .IDX_W(IDX_W), .CMD_LSB(CMD_LSB), .DATA_LSB(DATA_LSB)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .probeReq (probeReq),
  .probeIdx (probeIdx),
  .probeDly (probeDly),
  .probeAck (probeAck),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .chosen   (chosen)
);

// File: tb/sim_tune_top.sv
`timescale 1ns/1ps
module sim_tune_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dataMode = 1'b0;
  logic [31:0] storedDly = '0;
  logic [31:0] cfgIn = '0;
  logic [31:0] cfgOut;
  logic        cfgWe;
  logic        probeReq;
  logic [7:0]  probeIdx;
  logic [31:0] probeDly;
  logic        probeAck = 1'b0;
  logic        probePass = 1'b0;
  logic        busy, done, err;
  logic [7:0]  chosen;
  logic [31:0] dlyOut;

  always #2.5 clk = ~clk;

  tune_top u0 (.*);

  typedef struct packed {
    logic [31:0] dly;
    logic [7:0]  pick;
    logic        err;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          failures = 0;
  int          doneSeen = 0;
  logic [255:0] passMap = '0;
  bit          stallEn = 0;
  bit          toggle = 0;
  logic        expMode = 0;
  logic [31:0] expStored = '0;
  logic [31:0] expCfg = '0;
  int          expIdx = 0;
  int          seqBad = 0, laneBad = 0, cfgBad = 0, cfgSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input logic [31:0] w, input logic [7:0] v,
                                       input logic m);
    logic [31:0] r = w;
    if (m) r[23:16] = v; else r[15:8] = v;
    return r;
  endfunction

  function automatic logic [255:0] span(input int lo, input int hi);
    logic [255:0] r = '0;
    for (int i = lo; i <= hi; i++) r[i] = 1'b1;
    return r;
  endfunction

  // reference per requirements R5, R6, R7, R8, R9
  function automatic exp_t model(input logic [255:0] m, input logic [31:0] st,
                                 input logic md);
    exp_t e;
    int run = 0, best = 0, bend = 0;
    for (int i = 0; i < 256; i++) begin
      if (m[i]) run++;
      else begin
        if (run > best) begin best = run; bend = i - 1; end
        run = 0;
      end
    end
    if (run > best) begin best = run; bend = 255; end
    if (best == 0) begin
      e.err = 1'b1; e.pick = 8'd0; e.dly = st;
    end else begin
      e.err = 1'b0; e.pick = 8'(bend - (best - 1) / 2); e.dly = lane(st, e.pick, md);
    end
    return e;
  endfunction

  // responder and monitor, all on the falling edge
  always @(negedge clk) begin
    toggle <= ~toggle;
    if (cfgWe) begin
      cfgSeen++;
      if (cfgOut !== expCfg || expIdx != 0) cfgBad++;
    end
    if (probeReq && (!stallEn || toggle)) begin
      probeAck  <= 1'b1;
      probePass <= passMap[probeIdx];
      if (int'(probeIdx) != expIdx) seqBad++;
      if (probeDly !== lane(expStored, 8'(expIdx), expMode)) laneBad++;
      expIdx++;
    end else begin
      probeAck  <= 1'b0;
      probePass <= 1'b0;
    end
    if (done) begin
      exp_t e;
      doneSeen++;
      if (q.size() == 0) chk(0, "R10", "unexpected done", 32'd1, 32'd0);
      else begin
        e = q.pop_front();
        chk(err === e.err, "R9", "err", {31'd0, err}, {31'd0, e.err});
        chk(chosen === e.pick, "R7", "chosen", {24'd0, chosen}, {24'd0, e.pick});
        chk(dlyOut === e.dly, "R8", "dlyOut", dlyOut, e.dly);
      end
      chk(expIdx == 256 && seqBad == 0, "R3", "setting sequence",
          32'(expIdx), 32'd256);
      chk(laneBad == 0, "R4", "probeDly lane mismatches", 32'(laneBad), 32'd0);
      chk(cfgSeen == 1 && cfgBad == 0, "R2", "config write", 32'(cfgSeen), 32'd1);
    end
  end

  task automatic runTest(input logic md, input logic [31:0] st, input logic [31:0] cfg,
                         input logic [255:0] m, input bit stall, input bit poke);
    int target;
    exp_t e;
    passMap = m; stallEn = stall;
    expMode = md; expStored = st; expCfg = cfg & 32'hF0FF_FFFF;
    expIdx = 0; seqBad = 0; laneBad = 0; cfgBad = 0; cfgSeen = 0;
    e = model(m, st, md);
    q.push_back(e);
    target = doneSeen + 1;
    @(negedge clk);
    start = 1'b1; dataMode = md; storedDly = st; cfgIn = cfg;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: inputs changed mid-run must not disturb the run
      repeat (40) @(negedge clk);
      start = 1'b1; dataMode = ~md; storedDly = ~st; cfgIn = ~cfg;
      @(negedge clk);
      start = 1'b0;
    end
    wait (doneSeen == target);
    repeat (6) @(negedge clk);
    chk(!busy && !done, "R10", "idle after done", {30'd0, busy, done}, 32'd0);
    chk(dlyOut === e.dly && chosen === e.pick, "R10", "outputs hold", dlyOut, e.dly);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, err, cfgWe, probeReq} === 5'b0, "R1", "control outputs",
        {27'd0, busy, done, err, cfgWe, probeReq}, 32'd0);
    chk(chosen === 8'd0 && dlyOut === 32'd0, "R1", "result outputs", dlyOut, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R7/R8: single even-length window, command mode
    runTest(1'b0, 32'hA5C3_7E19, 32'hFFFF_FFFF, span(40, 59), 0, 0);
    // R5: tie between equal windows, earlier wins; data mode with stalls
    runTest(1'b1, 32'h1234_5678, 32'h0F00_00AA,
            span(10, 14) | span(100, 129) | span(200, 229), 1, 0);
    // R5: run counter restarts after a single failure
    runTest(1'b0, 32'h0000_0000, 32'h5A5A_5A5A, span(0, 9) | span(11, 25), 0, 0);
    // R9: all settings fail
    runTest(1'b1, 32'hDEAD_BEEF, 32'h0123_4567, '0, 0, 0);
    // R6: all pass, open run closed at 255
    runTest(1'b1, 32'h8000_0001, 32'hAAAA_AAAA, {256{1'b1}}, 0, 0);
    // R6: window touching 255 beats an earlier short one
    runTest(1'b0, 32'hCAFE_F00D, 32'h0, span(5, 9) | span(230, 255), 1, 0);
    // boundaries: single pass at 0, single pass at 255
    runTest(1'b1, 32'h0F0F_0F0F, 32'h0, span(0, 0), 0, 0);
    runTest(1'b0, 32'hF0F0_F0F0, 32'h0, span(255, 255), 0, 0);
    // R10: start and input changes while busy are ignored
    runTest(1'b0, 32'h7654_3210, 32'h0E00_0000, span(60, 90) | span(120, 122), 0, 1);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", 32'(q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule